// File: doc/BRIEF.md
# Four-Port Arrival-Order Arbiter

This block takes requests from four input ports, each with its own valid/ready handshake, and hands them out one at a time through a single output handshake. Each grant carries the number of the port that raised it. Requests leave in the order they arrived. When several ports are accepted on the same clock edge, the lower port number goes first.

Accepted port numbers are held in a small circular ordering store. Any mix of the four inputs can be accepted on one edge. One entry retires on each edge where the output handshake completes. Two limits apply to input acceptance. The store must have enough free room for every input at once. Each port is also held to a bounded number of requests still waiting for their grant. A stalled output keeps presenting the same head entry until it is taken.

Top module: `fcfs_arb4`

## Requirements
- R1: On one rising edge, every input port with both `in_valid[i]` and `in_ready[i]` high is accepted, so up to four requests can enter the store per edge.
- R2: At most one grant completes per edge. The head entry is removed only on an edge where `out_valid` and `out_ready` are both high.
- R3: Requests accepted on the same edge are granted in ascending port order: port 0 first, then 1, 2 and 3.
- R4: Requests accepted on different edges are granted in the order of their edges, whatever their port numbers.
- R5: The store holds at most `DEPTH` entries. All four `in_ready` bits are low while the free room is below four, and a request offered while `in_ready` is low is dropped without being recorded.
- R6: A port with `PORT_LIMIT` requests still waiting has its `in_ready` bit low. Valid on that port is then ignored, and the other ports are not affected.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_idx` does not change on the next edge.
- R8: After a synchronous active-low reset the store is empty, `out_valid` is low and all four `in_ready` bits are high.
- R9: Every accepted request is granted after a bounded number of edges with `out_ready` held high, even while other ports keep requesting on every edge.
- R10: `out_idx` is the 2-bit binary number of the port whose request is at the head of the store: 0 to 3 for ports 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 4 | Request valid, one bit per port |
| in_ready | output | 4 | Request accept permission, one bit per port |
| out_valid | output | 1 | A grant is being presented |
| out_ready | input | 1 | The consumer takes the presented grant |
| out_idx | output | 2 | Port number of the presented grant |

## Verification
The bench builds the block with its defaults: an eight-entry store and a limit of three waiting requests per port. With eight entries, two full rounds of all four ports fill the store exactly, so the edge where the free room drops below four is reached. A single port can reach its limit of three while the store still has five free entries, so the per-port limit can be seen on its own without the store-room limit masking it. Continuous requests from one port mixed with a single request from another show whether the single request waits forever.

// File: rtl/fcfs_pkg.sv
// Package: shared constants and types for the arrival-order arbiter.
// Assumes a fixed count of four requesting ports.
package fcfs_pkg;
    localparam int unsigned ARB_PORTS = 4;
    localparam int unsigned IDX_W     = $clog2(ARB_PORTS);
    localparam int unsigned PCNT_W    = $clog2(ARB_PORTS + 1);

    typedef logic [IDX_W-1:0]  port_idx_t;
    typedef logic [PCNT_W-1:0] push_cnt_t;
endpackage

// File: rtl/fcfs_enq_pack.sv
// Module: fcfs_enq_pack
// Turns the vector of ports accepted this edge into a compact list of port
// numbers in ascending order, plus a count. Slot 0 holds the lowest
// accepted port. Assumes the store writes slots 0..count-1 in order.
module fcfs_enq_pack
    import fcfs_pkg::*;
(
    input  logic [ARB_PORTS-1:0]                accepted,
    output port_idx_t [ARB_PORTS-1:0]           slots,
    output push_cnt_t                           push_cnt
);
    localparam int unsigned SLOT_W = $clog2(ARB_PORTS);

    // Purpose: walk ports low to high and append each accepted one.
    always_comb begin
        logic [PCNT_W-1:0] n;
        n     = '0;
        slots = '0;
        for (int i = 0; i < ARB_PORTS; i++) begin
            if (accepted[i]) begin
                slots[n[SLOT_W-1:0]] = port_idx_t'(i);
                n = n + 1'b1;
            end
        end
        push_cnt = n;
    end
endmodule

// File: rtl/fcfs_order_store.sv
// Module: fcfs_order_store
// Circular buffer of port numbers. It can write up to NPUSH entries and
// read one entry per edge. Assumes DEPTH is a power of two, and that the
// caller never pushes more than the free room allows.
module fcfs_order_store
    import fcfs_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  push_cnt_t                 push_cnt,
    input  port_idx_t [ARB_PORTS-1:0] push_data,
    input  logic                      pop,
    output port_idx_t                 head,
    output logic [$clog2(DEPTH+1)-1:0] occ
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned OCC_W = $clog2(DEPTH + 1);

    port_idx_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Purpose: write the packed slots at consecutive positions from wr_ptr.
    always_ff @(posedge clk) begin
        for (int k = 0; k < ARB_PORTS; k++) begin
            if (PCNT_W'(k) < push_cnt) begin
                mem[wr_ptr + PTR_W'(k)] <= push_data[k];
            end
        end
    end

    // Purpose: advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push_cnt);
            if (pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            occ <= occ + OCC_W'(push_cnt) - OCC_W'(pop);
        end
    end

    // Purpose: present the oldest entry.
    assign head = mem[rd_ptr];
endmodule

// File: rtl/fcfs_port_credit.sv
// Module: fcfs_port_credit
// Keeps one count per port of the requests still waiting for a grant, and
// reports which ports are under their limit. Assumes a grant of port p
// retires exactly one waiting request of p.
module fcfs_port_credit
    import fcfs_pkg::*;
#(
    parameter int unsigned PORT_LIMIT = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ARB_PORTS-1:0]      accepted,
    input  logic                      pop,
    input  port_idx_t                 pop_idx,
    output logic [ARB_PORTS-1:0]      under_limit,
    output logic [ARB_PORTS-1:0][$clog2(PORT_LIMIT+1)-1:0] pend
);
    localparam int unsigned CW = $clog2(PORT_LIMIT + 1);

    for (genvar p = 0; p < ARB_PORTS; p++) begin : g_port
        logic inc;
        logic dec;
        assign inc = accepted[p];
        assign dec = pop && (pop_idx == port_idx_t'(p));

        // Purpose: count waiting requests of this port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[p] <= '0;
            end else if (inc && !dec) begin
                pend[p] <= pend[p] + 1'b1;
            end else if (dec && !inc) begin
                pend[p] <= pend[p] - 1'b1;
            end
        end

        assign under_limit[p] = (pend[p] < CW'(PORT_LIMIT));
    end
endmodule

// File: rtl/fcfs_arb4.sv
// Module: fcfs_arb4 (top)
// Arbiter for four ports that grants in arrival order. Ports accepted on the
// same edge are ordered by port number. Input acceptance is gated by store
// room (room for all ports at once) and a per-port waiting limit.
// Assumes DEPTH is a power of two and at least ARB_PORTS.
module fcfs_arb4
    import fcfs_pkg::*;
#(
    parameter int unsigned DEPTH      = 8,
    parameter int unsigned PORT_LIMIT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] in_valid,
    output logic [3:0] in_ready,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [1:0] out_idx
);
    localparam int unsigned OCC_W = $clog2(DEPTH + 1);
    localparam int unsigned CW    = $clog2(PORT_LIMIT + 1);
    localparam int unsigned ROOM_MAX = DEPTH - ARB_PORTS;

    logic [ARB_PORTS-1:0]         accepted;
    port_idx_t [ARB_PORTS-1:0]    slots;
    push_cnt_t                    push_cnt;
    logic                         pop;
    port_idx_t                    head;
    logic [OCC_W-1:0]             occ;
    logic                         room_ok;
    logic [ARB_PORTS-1:0]         under_limit;
    logic [ARB_PORTS-1:0][CW-1:0] pend;

    // Purpose: input handshakes and output retirement.
    assign room_ok   = (occ <= OCC_W'(ROOM_MAX));
    assign in_ready  = {ARB_PORTS{room_ok}} & under_limit;
    assign accepted  = in_valid & in_ready;
    assign out_valid = (occ != '0);
    assign pop       = out_valid && out_ready;
    assign out_idx   = head;

    fcfs_enq_pack u_pack (
        .accepted (accepted),
        .slots    (slots),
        .push_cnt (push_cnt)
    );

    fcfs_order_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_cnt  (push_cnt),
        .push_data (slots),
        .pop       (pop),
        .head      (head),
        .occ       (occ)
    );

    fcfs_port_credit #(.PORT_LIMIT(PORT_LIMIT)) u_credit (
        .clk         (clk),
        .rst_n       (rst_n),
        .accepted    (accepted),
        .pop         (pop),
        .pop_idx     (head),
        .under_limit (under_limit),
        .pend        (pend)
    );
endmodule

// File: rtl/fcfs_arb4_chk.sv
// Module: fcfs_arb4_chk
// Checker bound to the top. It checks occupancy bookkeeping, room gating,
// per-port limits and the stability of a stalled grant.
module fcfs_arb4_chk #(
    parameter int unsigned DEPTH      = 8,
    parameter int unsigned PORT_LIMIT = 3
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic [3:0]                             in_ready,
    input logic                                   out_valid,
    input logic                                   out_ready,
    input logic [1:0]                             out_idx,
    input logic [$clog2(DEPTH+1)-1:0]             occ,
    input logic [2:0]                             push_cnt,
    input logic [3:0][$clog2(PORT_LIMIT+1)-1:0]   pend
);
    // R1 / R2: occupancy moves by the accepted count minus one per grant.
    a_r1_occ_track: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int'(occ) == int'($past(occ)) + int'($past(push_cnt))
                          - int'($past(out_valid && out_ready))));

    // R5: the store never holds more than DEPTH entries.
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= int'(DEPTH));

    // R5: not enough room for four means no input is ready.
    a_r5_room_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(occ) > int'(DEPTH) - 4) |-> (in_ready == 4'b0000));

    // R7: a stalled grant is held stable.
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_idx)));

    // R6: no port exceeds its waiting limit.
    for (genvar p = 0; p < 4; p++) begin : g_lim
        a_r6_port_limit: assert property (@(posedge clk) disable iff (!rst_n)
            int'(pend[p]) <= int'(PORT_LIMIT));
    end
endmodule

bind fcfs_arb4 fcfs_arb4_chk #(.DEPTH(DEPTH), .PORT_LIMIT(PORT_LIMIT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_idx   (out_idx),
    .occ       (occ),
    .push_cnt  (push_cnt),
    .pend      (pend)
);

// File: tb/fcfs_arb4_tb_top.sv
// Directed bench: a queue model built from the requirements predicts grants
// and ready bits on every edge.
module fcfs_arb4_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int LIMIT      = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] in_valid = '0;
    logic [3:0] in_ready;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [1:0] out_idx;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;
    int  model_q[$];
    int  granted[4];

    always #(CLK_PERIOD/2) clk = ~clk;

    fcfs_arb4 #(.DEPTH(DEPTH), .PORT_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_ready();
        logic [3:0] r;
        int cnt[4] = '{0, 0, 0, 0};
        foreach (model_q[k]) cnt[model_q[k]]++;
        for (int i = 0; i < 4; i++)
            r[i] = ((DEPTH - model_q.size()) >= 4) && (cnt[i] < LIMIT);
        return r;
    endfunction

    // One edge: drive, compare outputs against the model, then update it.
    task automatic step(logic [3:0] v, logic rdy, string tag);
        logic [3:0] acc;
        @(negedge clk);
        in_valid  = v;
        out_ready = rdy;
        #1;
        chk(in_ready == exp_ready(), tag, "in_ready", in_ready, exp_ready());
        chk(out_valid == (model_q.size() != 0), tag, "out_valid",
            out_valid, model_q.size() != 0);
        if (model_q.size() != 0)
            chk(out_idx == model_q[0], tag, "out_idx", out_idx, model_q[0]);
        acc = v & exp_ready();
        @(posedge clk);
        if (rdy && model_q.size() != 0) begin
            granted[model_q[0]]++;
            void'(model_q.pop_front());
        end
        for (int i = 0; i < 4; i++) if (acc[i]) model_q.push_back(i);
    endtask

    task automatic drain(string tag);
        while (model_q.size() != 0) step(4'b0000, 1'b1, tag);
        step(4'b0000, 1'b1, tag);
    endtask

    task automatic t_reset();   // R8
        @(negedge clk); #1;
        chk(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
        chk(in_ready == 4'hF, "R8", "in_ready after reset", in_ready, 15);
    endtask

    task automatic t_same_edge();   // R1, R3, R10
        step(4'hF, 1'b0, "R1");
        step(4'h0, 1'b0, "R1");
        drain("R3");
        step(4'b1010, 1'b0, "R10");
        drain("R10");
    endtask

    task automatic t_cross_edge();  // R4
        step(4'b1000, 1'b0, "R4");
        step(4'b0001, 1'b0, "R4");
        step(4'b0100, 1'b0, "R4");
        step(4'b0011, 1'b1, "R4");
        drain("R4");
    endtask

    task automatic t_stall();   // R7
        step(4'b0110, 1'b0, "R7");
        for (int k = 0; k < 3; k++) step(4'b0000, 1'b0, "R7");
        @(negedge clk); #1;
        chk(out_idx == 2'd1, "R7", "held head", out_idx, 1);
        drain("R7");
    endtask

    task automatic t_full();    // R5, R2
        step(4'hF, 1'b0, "R5");
        step(4'hF, 1'b0, "R5");
        step(4'hF, 1'b0, "R5");  // ready low: ignored
        step(4'hF, 1'b0, "R5");
        chk(model_q.size() == DEPTH, "R5", "model occupancy", model_q.size(), DEPTH);
        drain("R2");
    endtask

    task automatic t_limit();   // R6
        for (int k = 0; k < 5; k++) step(4'b0010, 1'b0, "R6");
        @(negedge clk); #1;
        chk(in_ready == 4'b1101, "R6", "limited port ready", in_ready, 13);
        drain("R6");
    endtask

    task automatic t_stream();  // R9
        int g3;
        g3 = granted[3];
        for (int k = 0; k < 20; k++)
            step((k == 2) ? 4'b1001 : 4'b0001, 1'b1, "R9");
        drain("R9");
        chk(granted[3] == g3 + 1, "R9", "port3 grants", granted[3], g3 + 1);
    endtask

    task automatic t_mixed();   // R1..R4 mixed traffic
        logic [3:0] pat[6] = '{4'b0101, 4'b1010, 4'b1111, 4'b0011, 4'b1100, 4'b0110};
        for (int k = 0; k < 12; k++) step(pat[k % 6], k[0], "R4");
        drain("R3");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_same_edge();
        t_cross_edge();
        t_stall();
        t_full();
        t_limit();
        t_stream();
        t_mixed();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule